// File: doc/BRIEF.md
# Record-Stream DMA Command Engine

This block is a read-only bus master that turns a packed byte stream held in memory into a series of timed output commands. Software loads a start address and writes 1 to the run bit. The engine then reads consecutive bus words from that address, takes bytes out of them one at a time, and parses self-describing records. Each record carries a channel, a 64-bit timestamp, a 16-bit register address and a payload of 1 to 64 bytes.

Every complete record leaves the block as one command on a valid/ready port. Records sit back to back with no padding, so a record may be split across several bus words. The stream ends with a zero length byte. When the engine reaches it, the engine drops the run bit by itself. Software polls that bit to learn that the run is over.

Top module: `dma_record_engine`

## Requirements
- R1: After reset the run bit reads 0, no bus cycle is requested and no command is valid.
- R2: Writing 1 to the run bit while it reads 0 starts a run and sets the run bit. The first word requested is the latched start address with its low log2(WORD_BYTES) bits forced to zero.
- R3: Words are requested at consecutive addresses, each WORD_BYTES above the previous one. A request holds its address until it is acknowledged, and no request is made while the run bit is 0.
- R4: Inside a fetched word, bytes are consumed from the most significant byte (bits [8*WORD_BYTES-1 -: 8]) downwards. Consumption continues into the next word with no gap, so records may straddle word boundaries.
- R5: A record is one length byte L followed by L-1 body bytes, which are read in this order:
  - 3 channel bytes;
  - 8 timestamp bytes;
  - 2 address bytes;
  - L-14 payload bytes.
  Each field is little-endian: the first byte of the field is bits [7:0]. The command reports the payload length as L-14 (1 to 64), and payload byte j appears at cmd_data_o[8j+7:8j].
- R6: Every cmd_data_o byte at or beyond the payload length is zero.
- R7: A length byte of 0 ends the run. No command is issued for it, the run bit clears and fetching stops.
- R8: While cmd_valid_o is high and cmd_ready_i is low, the command and all its fields hold steady. Each record is delivered exactly once, in stream order.
- R9: The start address is captured when a run starts. Address writes and run-bit writes made during a run do not affect that run, and a later run uses the newly written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_we_i | input | 1 | Write strobe for the start address |
| cfg_base_i | input | ADDR_W | Start address value (byte address) |
| cfg_en_we_i | input | 1 | Write strobe for the run bit |
| cfg_en_i | input | 1 | Value written to the run bit |
| cfg_en_o | output | 1 | Run bit; high while a run is in progress |
| bus_cyc_o | output | 1 | Bus cycle request |
| bus_stb_o | output | 1 | Bus strobe (read) |
| bus_adr_o | output | ADDR_W | Byte address of the requested word |
| bus_ack_i | input | 1 | Read acknowledge |
| bus_dat_i | input | 8*WORD_BYTES | Read data |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_chan_o | output | 24 | Channel |
| cmd_ts_o | output | 64 | Timestamp |
| cmd_addr_o | output | 16 | Register address |
| cmd_dlen_o | output | $clog2(MAX_DATA+1) | Payload length in bytes |
| cmd_data_o | output | 8*MAX_DATA | Payload, byte 0 in the low bits |

## Verification
The hardest situation to reach is a record that crosses one or more word boundaries while the command port is also holding back. The bench uses a narrow 4-byte bus and fills memory with records whose payload lengths sweep every value from 1 to 64. Record starts therefore land on every byte lane, and the longest records span about twenty words.

The second run pulses ready low in a repeating pattern, so the engine stalls while partway through words. During the first run the bench writes a junk address and a 0 to the run bit. The second run starts from an unaligned address that must round down, which shows both that the start address is captured at the start of a run and that its low bits are cleared.

// File: rtl/dma_rec_pkg.sv
package dma_rec_pkg;
  localparam int CHAN_BYTES = 3;
  localparam int TS_BYTES   = 8;
  localparam int RADR_BYTES = 2;
  // body bytes ahead of the payload
  localparam int PRE_BYTES  = CHAN_BYTES + TS_BYTES + RADR_BYTES;
  // record overhead including the length byte
  localparam int HDR_BYTES  = PRE_BYTES + 1;

  typedef enum logic [1:0] {
    P_LEN  = 2'd0,
    P_BODY = 2'd1,
    P_EMIT = 2'd2
  } parse_st_e;
endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              en_we_i,
  input  logic              en_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              en_o,
  output logic              start_o
);
  logic [ADDR_W-1:0] base_q;
  logic              en_q;

  // only an idle engine can be started; other run-bit writes are dropped
  assign start_o = en_we_i & en_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (base_we_i) base_q <= base_i;
      if (start_o)     en_q <= 1'b1;
      else if (done_i) en_q <= 1'b0;
    end
  end

  assign base_o = base_q;
  assign en_o   = en_q;
endmodule

// File: rtl/dma_word_fetch.sv
module dma_word_fetch #(
  parameter int WORD_BYTES = 64,
  parameter int ADDR_W     = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic                    active_i,
  input  logic                    flush_i,
  output logic                    stb_o,
  output logic [ADDR_W-1:0]       adr_o,
  input  logic                    ack_i,
  input  logic [8*WORD_BYTES-1:0] dat_i,
  output logic [7:0]              byte_o,
  output logic                    byte_valid_o,
  input  logic                    byte_ready_i
);
  localparam int WBITS = 8 * WORD_BYTES;
  localparam int OFF_W = $clog2(WORD_BYTES);
  localparam int CNT_W = $clog2(WORD_BYTES + 1);

  logic [ADDR_W-1:0] adr_q;
  logic [WBITS-1:0]  word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  assign stb_o        = active_i && (cnt_q == '0);
  assign adr_o        = adr_q;
  assign byte_o       = word_q[WBITS-1 -: 8];
  assign byte_valid_o = active_i && (cnt_q != '0);
  assign take         = byte_valid_o && byte_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      adr_q <= {base_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (stb_o && ack_i) begin
      word_q <= dat_i;
      cnt_q  <= CNT_W'(WORD_BYTES);
      adr_q  <= adr_q + ADDR_W'(WORD_BYTES);
    end else if (take) begin
      word_q <= {word_q[WBITS-9:0], 8'h00};
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dma_rec_parse.sv
module dma_rec_parse
  import dma_rec_pkg::*;
#(
  parameter int MAX_DATA = 64,
  parameter int DLEN_W   = $clog2(MAX_DATA + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [7:0]            byte_i,
  input  logic                  byte_valid_i,
  output logic                  byte_ready_o,
  output logic                  end_o,
  output logic                  cmd_valid_o,
  input  logic                  cmd_ready_i,
  output logic [23:0]           cmd_chan_o,
  output logic [63:0]           cmd_ts_o,
  output logic [15:0]           cmd_addr_o,
  output logic [DLEN_W-1:0]     cmd_dlen_o,
  output logic [8*MAX_DATA-1:0] cmd_data_o
);
  parse_st_e             st_q;
  logic [7:0]            len_q;
  logic [7:0]            idx_q;
  logic [23:0]           chan_q;
  logic [63:0]           ts_q;
  logic [15:0]           radr_q;
  logic [8*MAX_DATA-1:0] data_q;
  logic                  take;
  logic [7:0]            dlen_full;

  assign byte_ready_o = (st_q != P_EMIT);
  assign take         = byte_valid_i && byte_ready_o;
  assign end_o        = take && (st_q == P_LEN) && (byte_i == 8'h00);
  assign cmd_valid_o  = (st_q == P_EMIT);
  assign dlen_full    = len_q - 8'(HDR_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_LEN;
      len_q  <= '0;
      idx_q  <= '0;
      chan_q <= '0;
      ts_q   <= '0;
      radr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      st_q <= P_LEN;
    end else begin
      unique case (st_q)
        P_LEN: if (take && byte_i != 8'h00) begin
          len_q  <= byte_i;
          idx_q  <= '0;
          data_q <= '0;
          st_q   <= (byte_i == 8'h01) ? P_EMIT : P_BODY;
        end
        P_BODY: if (take) begin
          for (int b = 0; b < CHAN_BYTES; b++)
            if (idx_q == 8'(b)) chan_q[8*b +: 8] <= byte_i;
          for (int b = 0; b < TS_BYTES; b++)
            if (idx_q == 8'(CHAN_BYTES + b)) ts_q[8*b +: 8] <= byte_i;
          for (int b = 0; b < RADR_BYTES; b++)
            if (idx_q == 8'(CHAN_BYTES + TS_BYTES + b)) radr_q[8*b +: 8] <= byte_i;
          for (int b = 0; b < MAX_DATA; b++)
            if (idx_q == 8'(PRE_BYTES + b)) data_q[8*b +: 8] <= byte_i;
          idx_q <= idx_q + 8'd1;
          if (idx_q == len_q - 8'd2) st_q <= P_EMIT;
        end
        P_EMIT: if (cmd_ready_i) st_q <= P_LEN;
        default: st_q <= P_LEN;
      endcase
    end
  end

  assign cmd_chan_o = chan_q;
  assign cmd_ts_o   = ts_q;
  assign cmd_addr_o = radr_q;
  assign cmd_dlen_o = dlen_full[DLEN_W-1:0];
  assign cmd_data_o = data_q;
endmodule

// File: rtl/dma_record_engine.sv
module dma_record_engine #(
  parameter int WORD_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int MAX_DATA   = 64,
  localparam int DLEN_W    = $clog2(MAX_DATA + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_base_we_i,
  input  logic [ADDR_W-1:0]       cfg_base_i,
  input  logic                    cfg_en_we_i,
  input  logic                    cfg_en_i,
  output logic                    cfg_en_o,
  output logic                    bus_cyc_o,
  output logic                    bus_stb_o,
  output logic [ADDR_W-1:0]       bus_adr_o,
  input  logic                    bus_ack_i,
  input  logic [8*WORD_BYTES-1:0] bus_dat_i,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [23:0]             cmd_chan_o,
  output logic [63:0]             cmd_ts_o,
  output logic [15:0]             cmd_addr_o,
  output logic [DLEN_W-1:0]       cmd_dlen_o,
  output logic [8*MAX_DATA-1:0]   cmd_data_o
);
  logic [ADDR_W-1:0] base;
  logic              start;
  logic              done;
  logic              stb;
  logic [7:0]        sbyte;
  logic              sbyte_valid;
  logic              sbyte_ready;

  dma_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_we_i (cfg_base_we_i),
    .base_i    (cfg_base_i),
    .en_we_i   (cfg_en_we_i),
    .en_i      (cfg_en_i),
    .done_i    (done),
    .base_o    (base),
    .en_o      (cfg_en_o),
    .start_o   (start)
  );

  dma_word_fetch #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .base_i       (base),
    .active_i     (cfg_en_o),
    .flush_i      (done),
    .stb_o        (stb),
    .adr_o        (bus_adr_o),
    .ack_i        (bus_ack_i),
    .dat_i        (bus_dat_i),
    .byte_o       (sbyte),
    .byte_valid_o (sbyte_valid),
    .byte_ready_i (sbyte_ready)
  );

  dma_rec_parse #(.MAX_DATA(MAX_DATA)) u_parse (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .byte_i       (sbyte),
    .byte_valid_i (sbyte_valid),
    .byte_ready_o (sbyte_ready),
    .end_o        (done),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_chan_o   (cmd_chan_o),
    .cmd_ts_o     (cmd_ts_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_dlen_o   (cmd_dlen_o),
    .cmd_data_o   (cmd_data_o)
  );

  assign bus_stb_o = stb;
  assign bus_cyc_o = stb;
endmodule

// File: rtl/dma_record_engine_chk.sv
module dma_record_engine_chk #(
  parameter int WORD_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int MAX_DATA   = 64,
  parameter int DLEN_W     = $clog2(MAX_DATA + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_en_o,
  input logic                  bus_stb_o,
  input logic [ADDR_W-1:0]     bus_adr_o,
  input logic                  bus_ack_i,
  input logic                  cmd_valid_o,
  input logic                  cmd_ready_i,
  input logic [23:0]           cmd_chan_o,
  input logic [63:0]           cmd_ts_o,
  input logic [15:0]           cmd_addr_o,
  input logic [DLEN_W-1:0]     cmd_dlen_o,
  input logic [8*MAX_DATA-1:0] cmd_data_o
);
  assert_idle_no_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_o |-> !bus_stb_o);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o && !bus_ack_i |=> bus_stb_o && $stable(bus_adr_o));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o && bus_ack_i |=> bus_adr_o == $past(bus_adr_o) + ADDR_W'(WORD_BYTES));

  assert_cmd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_chan_o) &&
      $stable(cmd_ts_o) && $stable(cmd_addr_o) && $stable(cmd_dlen_o) &&
      $stable(cmd_data_o));

  assert_cmd_in_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cfg_en_o);

  assert_dlen_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_dlen_o != '0) && (cmd_dlen_o <= DLEN_W'(MAX_DATA)));
endmodule

bind dma_record_engine dma_record_engine_chk #(
  .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W), .MAX_DATA(MAX_DATA)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_en_o    (cfg_en_o),
  .bus_stb_o   (bus_stb_o),
  .bus_adr_o   (bus_adr_o),
  .bus_ack_i   (bus_ack_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_chan_o  (cmd_chan_o),
  .cmd_ts_o    (cmd_ts_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_dlen_o  (cmd_dlen_o),
  .cmd_data_o  (cmd_data_o)
);

// File: tb/dma_record_engine_test.sv
module dma_record_engine_test;
  localparam int WB     = 4;
  localparam int AW     = 16;
  localparam int MD     = 64;
  localparam int DW     = $clog2(MD + 1);
  localparam int MEM_SZ = 3072;
  localparam int RUN2_B = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            base_we = 1'b0;
  logic [AW-1:0]   base_v = '0;
  logic            en_we = 1'b0;
  logic            en_v = 1'b0;
  logic            en_o;
  logic            cyc, stb;
  logic [AW-1:0]   adr;
  logic            ack = 1'b0;
  logic [8*WB-1:0] dat = '0;
  logic            cvalid;
  logic            cready = 1'b1;
  logic [23:0]     cchan;
  logic [63:0]     cts;
  logic [15:0]     caddr;
  logic [DW-1:0]   cdlen;
  logic [8*MD-1:0] cdata;

  logic [7:0] mem [MEM_SZ];
  int  n_chk = 0, n_bad = 0;
  int  rec_k = 0;
  int  cyc_n = 0;
  bit  bp = 1'b0;

  always #10 clk = ~clk;

  dma_record_engine #(.WORD_BYTES(WB), .ADDR_W(AW), .MAX_DATA(MD)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_base_we_i(base_we), .cfg_base_i(base_v),
    .cfg_en_we_i(en_we), .cfg_en_i(en_v), .cfg_en_o(en_o),
    .bus_cyc_o(cyc), .bus_stb_o(stb), .bus_adr_o(adr),
    .bus_ack_i(ack), .bus_dat_i(dat),
    .cmd_valid_o(cvalid), .cmd_ready_i(cready),
    .cmd_chan_o(cchan), .cmd_ts_o(cts), .cmd_addr_o(caddr),
    .cmd_dlen_o(cdlen), .cmd_data_o(cdata)
  );

  function automatic logic [23:0] f_chan(int k);
    return 24'h0A0000 + 24'(k * 257);
  endfunction
  function automatic logic [63:0] f_ts(int k);
    return 64'h0123_4567_89AB_0000 + 64'(k) * 64'h1_0001_0003;
  endfunction
  function automatic logic [15:0] f_adr(int k);
    return 16'h8000 ^ 16'(k * 97);
  endfunction
  function automatic logic [7:0] f_pay(int k, int j);
    return 8'((k * 29 + j * 11 + 3) & 255);
  endfunction
  function automatic logic [8*MD-1:0] f_data(int k);
    logic [8*MD-1:0] d = '0;
    for (int j = 0; j < k + 1; j++) d[8*j +: 8] = f_pay(k, j);
    return d;
  endfunction

  task automatic put_rec(int k, inout int p);
    logic [23:0] c = f_chan(k);
    logic [63:0] t = f_ts(k);
    logic [15:0] a = f_adr(k);
    mem[p] = 8'(14 + k + 1); p++;
    for (int i = 0; i < 3; i++) begin mem[p] = c[8*i +: 8]; p++; end
    for (int i = 0; i < 8; i++) begin mem[p] = t[8*i +: 8]; p++; end
    for (int i = 0; i < 2; i++) begin mem[p] = a[8*i +: 8]; p++; end
    for (int j = 0; j < k + 1; j++) begin mem[p] = f_pay(k, j); p++; end
  endtask

  task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle registered acknowledge, first byte in the word MSB
  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    cready <= !bp || ((cyc_n % 5) != 1 && (cyc_n % 5) != 2);
    if (stb && !ack) begin
      ack <= 1'b1;
      for (int i = 0; i < WB; i++)
        dat[8*(WB-1-i) +: 8] <= (int'(adr) + i < MEM_SZ) ? mem[int'(adr) + i] : 8'hA5;
    end else begin
      ack <= 1'b0;
    end
  end

  // command monitor; R4 R5 R6 R8 checked per accepted record
  always @(negedge clk) begin
    if (rst_n && cvalid && cready) begin
      chk(cchan == f_chan(rec_k), "R5", $sformatf("chan rec%0d", rec_k), 512'(cchan), 512'(f_chan(rec_k)));
      chk(cts == f_ts(rec_k), "R5", $sformatf("ts rec%0d", rec_k), 512'(cts), 512'(f_ts(rec_k)));
      chk(caddr == f_adr(rec_k), "R4", $sformatf("addr rec%0d", rec_k), 512'(caddr), 512'(f_adr(rec_k)));
      chk(cdlen == DW'(rec_k + 1), "R5", $sformatf("dlen rec%0d", rec_k), 512'(cdlen), 512'(rec_k + 1));
      chk(cdata == f_data(rec_k), "R6", $sformatf("data rec%0d", rec_k), cdata, f_data(rec_k));
      rec_k <= rec_k + 1;
    end
  end

  task automatic wr_base(logic [AW-1:0] v);
    @(negedge clk); base_we = 1'b1; base_v = v;
    @(negedge clk); base_we = 1'b0;
  endtask
  task automatic wr_en(logic v);
    @(negedge clk); en_we = 1'b1; en_v = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic run(logic [AW-1:0] exp_base, int last_k, bit meddle);
    wr_en(1'b1);
    chk(en_o == 1'b1, "R2", "run bit after start", 512'(en_o), 512'(1));
    while (!stb) @(negedge clk);
    chk(adr == exp_base, "R2", "first fetch address", 512'(adr), 512'(exp_base));
    if (meddle) begin
      repeat (40) @(negedge clk);
      wr_base(16'h0010);   // R9: ignored for this run
      wr_en(1'b0);         // R9: ignored
      wr_base(16'(RUN2_B + 3));
    end
    while (en_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rec_k == last_k, "R7", "records delivered", 512'(rec_k), 512'(last_k));
    chk(!cvalid && !stb, "R7", "quiet after end", 512'({cvalid, stb}), 512'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p;
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'hA5;
    p = 0;
    for (int k = 0; k < 32; k++) put_rec(k, p);
    mem[p] = 8'h00;
    p = RUN2_B;
    for (int k = 32; k < 64; k++) put_rec(k, p);
    mem[p] = 8'h00;

    repeat (3) @(negedge clk);
    chk(!en_o, "R1", "run bit in reset", 512'(en_o), 512'(0));
    chk(!cyc && !stb, "R1", "bus idle in reset", 512'({cyc, stb}), 512'(0));
    chk(!cvalid, "R1", "no command in reset", 512'(cvalid), 512'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!stb && !en_o, "R1", "idle after reset", 512'({stb, en_o}), 512'(0));

    wr_base('0);
    run('0, 32, 1'b1);
    bp = 1'b1;                       // R8: back-pressure on run 2
    run(16'(RUN2_B), 64, 1'b0);      // R9: base 1027 rounds to 1024

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule